// File: doc/BRIEF.md
# Address-Masked APB General-Purpose I/O

This peripheral gives software control over eight general-purpose pins through an APB-style register bus. Each pin can be an input or a driven output, and each can be handed over to a hardware function inside the chip. Pin inputs are brought into the clock domain by a synchroniser. A rising edge on a synchronised input is latched as a pending event. A per-pin enable gates that event onto a single interrupt line.

The data register does not sit at a single address. It occupies a window of 256 word addresses, and the word address itself carries an 8-bit mask. Bit i of the mask is address bit i+2. A read returns only the masked bits and returns 0 for the others. A write changes only the masked bits. Software can therefore set or clear any group of pins with one store and no read-modify-write sequence.

The bus side runs a three-state phase tracker: `BUS_IDLE`, `BUS_SETUP` and `BUS_ACCESS`. Transitions: `BUS_IDLE` goes to `BUS_SETUP` on psel with penable low and otherwise stays. `BUS_SETUP` goes to `BUS_ACCESS` on psel with penable high, stays on psel with penable low, and otherwise returns to `BUS_IDLE`. `BUS_ACCESS` goes to `BUS_SETUP` on psel with penable low and otherwise returns to `BUS_IDLE`. A register access happens only in the enable cycle that follows a setup cycle, which is the `BUS_SETUP` to `BUS_ACCESS` transition.

Top module: `gpio_masked_apb`

## Requirements
- R1: After reset, every register reads 0, gpio_out and gpio_oe are 0, and irq is 0.
- R2: A write to an aligned address 0x000–0x3FC updates only those data bits whose mask bit is 1, where mask bit i is paddr[i+2]. The other bits keep their value. In software mode the data bits drive gpio_out.
- R3: A read of the data window returns the synchronised pin value where the mask bit is 1 and 0 where it is 0.
- R4: Offset 0x400 holds the direction bits and reads back what was written. In software mode, bit i = 1 drives gpio_oe[i] high (output) and 0 leaves the pin an input.
- R5: Offset 0x420 holds the mode bits and reads back. Where bit i = 1, gpio_out[i] and gpio_oe[i] follow hw_out[i] and hw_oe[i]. Where bit i = 0, they follow the data and direction registers.
- R6: gpio_in passes through a two-stage synchroniser. A level change becomes visible to data reads and edge detection within three clock edges.
- R7: Offset 0x414 (read-only) shows the pending bits. A bit sets on a rising edge of its synchronised input and stays set until cleared. Falling edges set nothing.
- R8: A write to offset 0x41C clears each pending bit whose write-data bit is 1 and leaves the others unchanged. A rising edge in the same cycle wins over the clear.
- R9: Offset 0x410 holds the interrupt-enable bits. Offset 0x418 (read-only) returns pending AND enable. irq is 1 exactly when that result is non-zero.
- R10: Reads of unmapped or unaligned offsets (including 0x404, 0x408, 0x40C and any paddr[1:0] ≠ 0) return 0. Writes to them, or to 0x414 or 0x418, change no register.
- R11: A register access happens only in an enable cycle (psel and penable high) that follows a setup cycle (psel high, penable low). An enable cycle with no setup before it is ignored. pready is always 1, and prdata is 0 outside a read access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus and register clock |
| presetn | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Peripheral select |
| penable | input | 1 | Enable phase marker |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte address |
| pwdata | input | NPINS | Write data |
| prdata | output | NPINS | Read data, valid during a read access |
| pready | output | 1 | Transfer complete, tied high |
| gpio_in | input | NPINS | Asynchronous pin levels |
| gpio_out | output | NPINS | Pin output values |
| gpio_oe | output | NPINS | Pin output enables |
| hw_out | input | NPINS | Hardware-function output values |
| hw_oe | input | NPINS | Hardware-function output enables |
| irq | output | 1 | Combined interrupt |

## Verification
The bench builds the block with its defaults: NPINS = 8 and SYNC_STAGES = 2. With eight pins, the address-mask window covers all 256 mask patterns, so random masks reach every combination of kept and replaced bits. Two synchroniser stages give a fixed, short settle time, so random pin toggles can be followed by pending-bit and interrupt checks without long waits. A deliberately bare enable cycle exercises the phase tracker's rejection path.

// File: rtl/gpio_am_pkg.sv
package gpio_am_pkg;

    localparam int ADDR_W = 12;

    typedef enum logic [1:0] {
        BUS_IDLE   = 2'd0,
        BUS_SETUP  = 2'd1,
        BUS_ACCESS = 2'd2
    } bus_state_e;

    typedef enum logic [2:0] {
        SEL_NONE = 3'd0,
        SEL_DATA = 3'd1,
        SEL_DIR  = 3'd2,
        SEL_IE   = 3'd3,
        SEL_RAW  = 3'd4,
        SEL_MIS  = 3'd5,
        SEL_CLR  = 3'd6,
        SEL_MODE = 3'd7
    } reg_sel_e;

    localparam logic [ADDR_W-1:0] OFS_DIR  = 12'h400;
    localparam logic [ADDR_W-1:0] OFS_IE   = 12'h410;
    localparam logic [ADDR_W-1:0] OFS_RAW  = 12'h414;
    localparam logic [ADDR_W-1:0] OFS_MIS  = 12'h418;
    localparam logic [ADDR_W-1:0] OFS_CLR  = 12'h41C;
    localparam logic [ADDR_W-1:0] OFS_MODE = 12'h420;

    // Aligned addresses below 0x400 form the masked data window.
    function automatic reg_sel_e addr_decode(input logic [ADDR_W-1:0] a);
        reg_sel_e s;
        s = SEL_NONE;
        if (a[1:0] == 2'b00) begin
            if (a[ADDR_W-1:10] == '0) begin
                s = SEL_DATA;
            end else begin
                unique case (a)
                    OFS_DIR:  s = SEL_DIR;
                    OFS_IE:   s = SEL_IE;
                    OFS_RAW:  s = SEL_RAW;
                    OFS_MIS:  s = SEL_MIS;
                    OFS_CLR:  s = SEL_CLR;
                    OFS_MODE: s = SEL_MODE;
                    default:  s = SEL_NONE;
                endcase
            end
        end
        return s;
    endfunction

endpackage

// File: rtl/gpio_am_busfsm.sv
module gpio_am_busfsm
    import gpio_am_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic psel,
    input  logic penable,
    input  logic pwrite,
    output logic wr_stb,
    output logic rd_stb,
    output logic ready
);

    bus_state_e st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= BUS_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            BUS_IDLE: begin
                if (psel && !penable) st_d = BUS_SETUP;
                else                  st_d = BUS_IDLE;
            end
            BUS_SETUP: begin
                if (psel && penable)       st_d = BUS_ACCESS;
                else if (psel && !penable) st_d = BUS_SETUP;
                else                       st_d = BUS_IDLE;
            end
            BUS_ACCESS: begin
                if (psel && !penable) st_d = BUS_SETUP;
                else                  st_d = BUS_IDLE;
            end
            default: st_d = BUS_IDLE;
        endcase
    end

    // Outputs: an access is the enable cycle seen while in BUS_SETUP.
    always_comb begin
        wr_stb = 1'b0;
        rd_stb = 1'b0;
        ready  = 1'b1;
        unique case (st_q)
            BUS_SETUP: begin
                wr_stb = psel && penable && pwrite;
                rd_stb = psel && penable && !pwrite;
            end
            default: begin
                wr_stb = 1'b0;
                rd_stb = 1'b0;
            end
        endcase
    end

    AST_SETUP_BEFORE_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb || rd_stb) |-> $past(psel && !penable)) else $error("setup rule"); // R11

    AST_ONE_KIND: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_stb && rd_stb)) else $error("both strobes"); // R11

endmodule

// File: rtl/gpio_am_sync.sv
module gpio_am_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    logic [STAGES-1:0][W-1:0] stg_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg_q <= '0;
        end else begin
            stg_q[0] <= din;
            for (int s = 1; s < STAGES; s++) begin
                stg_q[s] <= stg_q[s-1];
            end
        end
    end

    assign dout = stg_q[STAGES-1];

    initial begin
        AST_STAGES_MIN: assert (STAGES >= 2) else $error("too few stages"); // R6
    end

endmodule

// File: rtl/gpio_am_irq.sv
module gpio_am_irq #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_s,
    input  logic         clr_stb,
    input  logic [W-1:0] clr_bits,
    input  logic [W-1:0] ie,
    output logic [W-1:0] raw,
    output logic [W-1:0] masked,
    output logic         irq
);

    logic [W-1:0] prev_q;
    logic [W-1:0] rise;
    logic [W-1:0] clr_eff;

    assign rise    = pin_s & ~prev_q;
    assign clr_eff = clr_stb ? clr_bits : '0;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
            raw    <= '0;
        end else begin
            prev_q <= pin_s;
            raw    <= (raw & ~clr_eff) | rise;
        end
    end

    assign masked = raw & ie;
    assign irq    = |masked;

    AST_EDGE_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(rise) & ~raw) == '0)) else $error("edge lost"); // R7

    AST_RAW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(raw) & ~$past(clr_eff) & ~raw) == '0)) else $error("pending dropped"); // R7

    AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(clr_eff & ~rise) & raw) == '0)) else $error("clear ignored"); // R8

endmodule

// File: rtl/gpio_masked_apb.sv
module gpio_masked_apb
    import gpio_am_pkg::*;
#(
    parameter int NPINS       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              pclk,
    input  logic              presetn,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:0] paddr,
    input  logic [NPINS-1:0]  pwdata,
    output logic [NPINS-1:0]  prdata,
    output logic              pready,
    input  logic [NPINS-1:0]  gpio_in,
    output logic [NPINS-1:0]  gpio_out,
    output logic [NPINS-1:0]  gpio_oe,
    input  logic [NPINS-1:0]  hw_out,
    input  logic [NPINS-1:0]  hw_oe,
    output logic              irq
);

    localparam int MASK_LSB = 2;

    logic             wr_stb, rd_stb;
    reg_sel_e         sel;
    logic [NPINS-1:0] amask;
    logic [NPINS-1:0] data_q, dir_q, ie_q, mode_q;
    logic [NPINS-1:0] pin_s, raw, masked;
    logic             clr_go;
    logic [NPINS-1:0] rd_val;

    gpio_am_busfsm u_bus (
        .clk     (pclk),
        .rst_n   (presetn),
        .psel    (psel),
        .penable (penable),
        .pwrite  (pwrite),
        .wr_stb  (wr_stb),
        .rd_stb  (rd_stb),
        .ready   (pready)
    );

    gpio_am_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (pclk),
        .rst_n (presetn),
        .din   (gpio_in),
        .dout  (pin_s)
    );

    assign sel    = addr_decode(paddr);
    assign amask  = paddr[MASK_LSB +: NPINS];
    assign clr_go = wr_stb && (sel == SEL_CLR);

    gpio_am_irq #(.W(NPINS)) u_irq (
        .clk      (pclk),
        .rst_n    (presetn),
        .pin_s    (pin_s),
        .clr_stb  (clr_go),
        .clr_bits (pwdata),
        .ie       (ie_q),
        .raw      (raw),
        .masked   (masked),
        .irq      (irq)
    );

    always_ff @(posedge pclk or negedge presetn) begin
        if (!presetn) begin
            data_q <= '0;
            dir_q  <= '0;
            ie_q   <= '0;
            mode_q <= '0;
        end else if (wr_stb) begin
            unique case (sel)
                SEL_DATA: data_q <= (data_q & ~amask) | (pwdata & amask);
                SEL_DIR:  dir_q  <= pwdata;
                SEL_IE:   ie_q   <= pwdata;
                SEL_MODE: mode_q <= pwdata;
                default:  ;
            endcase
        end
    end

    always_comb begin
        rd_val = '0;
        if (rd_stb) begin
            unique case (sel)
                SEL_DATA: rd_val = pin_s & amask;
                SEL_DIR:  rd_val = dir_q;
                SEL_IE:   rd_val = ie_q;
                SEL_RAW:  rd_val = raw;
                SEL_MIS:  rd_val = masked;
                SEL_MODE: rd_val = mode_q;
                default:  rd_val = '0;
            endcase
        end
    end

    assign prdata = rd_val;

    // Per-pin steering between register control and the hardware function.
    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        assign gpio_out[i] = mode_q[i] ? hw_out[i] : data_q[i];
        assign gpio_oe[i]  = mode_q[i] ? hw_oe[i]  : dir_q[i];
    end

    AST_MASK_KEEPS: assert property (@(posedge pclk) disable iff (!presetn)
        (wr_stb && sel == SEL_DATA) |=> (((data_q ^ $past(data_q)) & ~$past(amask)) == '0)) else $error("unmasked bit changed"); // R2

    AST_MASK_WRITES: assert property (@(posedge pclk) disable iff (!presetn)
        (wr_stb && sel == SEL_DATA) |=> (((data_q ^ $past(pwdata)) & $past(amask)) == '0)) else $error("masked bit not written"); // R2

    AST_DATA_HOLD: assert property (@(posedge pclk) disable iff (!presetn)
        !(wr_stb && sel == SEL_DATA) |=> $stable(data_q)) else $error("data moved"); // R10

    AST_CTRL_HOLD: assert property (@(posedge pclk) disable iff (!presetn)
        !(wr_stb && (sel == SEL_DIR || sel == SEL_IE || sel == SEL_MODE)) |=> ($stable(dir_q) && $stable(ie_q) && $stable(mode_q))) else $error("control moved"); // R10

    AST_IRQ_GATED: assert property (@(posedge pclk) disable iff (!presetn)
        (ie_q == '0) |-> !irq) else $error("irq while disabled"); // R9

    AST_PRDATA_IDLE: assert property (@(posedge pclk) disable iff (!presetn)
        !rd_stb |-> (prdata == '0)) else $error("stray read data"); // R11

endmodule

// File: tb/gpio_masked_apb_tb.sv
`timescale 1ns/1ps
module gpio_masked_apb_tb;

    logic        pclk = 1'b0;
    logic        presetn = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [11:0] paddr = '0;
    logic [7:0]  pwdata = '0;
    logic [7:0]  prdata;
    logic        pready;
    logic [7:0]  gpio_in = '0;
    logic [7:0]  gpio_out, gpio_oe;
    logic [7:0]  hw_out = '0, hw_oe = '0;
    logic        irq;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    logic [7:0] m_data = '0, m_dir = '0, m_ie = '0, m_mode = '0, m_raw = '0, m_pin = '0;

    always #2 pclk = ~pclk;

    gpio_masked_apb u_dut (
        .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
        .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
        .pready(pready), .gpio_in(gpio_in), .gpio_out(gpio_out), .gpio_oe(gpio_oe),
        .hw_out(hw_out), .hw_oe(hw_oe), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_out();
        return (m_mode & hw_out) | (~m_mode & m_data);
    endfunction

    function automatic logic [7:0] exp_oe();
        return (m_mode & hw_oe) | (~m_mode & m_dir);
    endfunction

    function automatic logic exp_irq();
        return |(m_raw & m_ie);
    endfunction

    task automatic apb_wr(input logic [11:0] a, input logic [7:0] d);
        @(negedge pclk); psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
        @(negedge pclk); penable = 1;
        @(negedge pclk); psel = 0; penable = 0; pwrite = 0;
    endtask

    task automatic apb_rd(input logic [11:0] a, output logic [7:0] d);
        @(negedge pclk); psel = 1; penable = 0; pwrite = 0; paddr = a;
        @(negedge pclk); penable = 1;
        #1 d = prdata;
        @(negedge pclk); psel = 0; penable = 0;
    endtask

    task automatic set_pins(input logic [7:0] v);
        @(negedge pclk); gpio_in = v;
        repeat (3) @(negedge pclk);
        m_raw = m_raw | (v & ~m_pin);
        m_pin = v;
    endtask

    task automatic chk_pins(input string req);
        chk(req, gpio_out, exp_out());
        chk(req, gpio_oe, exp_oe());
        chk(req, irq, exp_irq());
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog act=hung exp=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        logic [7:0] msk;
        repeat (4) @(negedge pclk);
        presetn = 1;
        @(negedge pclk);

        // R1 reset state
        chk("R1 out", gpio_out, 8'h00);
        chk("R1 oe", gpio_oe, 8'h00);
        chk("R1 irq", irq, 1'b0);
        apb_rd(12'h400, rd); chk("R1 dir", rd, 8'h00);
        apb_rd(12'h410, rd); chk("R1 ie", rd, 8'h00);
        apb_rd(12'h420, rd); chk("R1 mode", rd, 8'h00);
        apb_rd(12'h414, rd); chk("R1 raw", rd, 8'h00);
        apb_rd(12'h3FC, rd); chk("R1 data", rd, 8'h00);

        // R11 pready and idle prdata
        chk("R11 pready", pready, 1'b1);
        chk("R11 prdata idle", prdata, 8'h00);

        // R4 direction
        apb_wr(12'h400, 8'hFF); m_dir = 8'hFF;
        apb_rd(12'h400, rd); chk("R4 dir readback", rd, 8'hFF);
        chk("R4 oe", gpio_oe, 8'hFF);

        // R2 masked writes: mask = paddr[9:2]
        apb_wr(12'h03C, 8'hFF); m_data = 8'h0F; chk("R2 low nibble", gpio_out, 8'h0F);
        apb_wr(12'h3C0, 8'h00); chk("R2 clear high", gpio_out, 8'h0F);
        apb_wr(12'h280, 8'hFF); m_data = 8'hAF; chk("R2 mask A0", gpio_out, 8'hAF);
        apb_wr(12'h000, 8'h00); chk("R2 empty mask", gpio_out, 8'hAF);

        // R3 / R6 masked reads after synchroniser
        set_pins(8'h5A);
        apb_rd(12'h3FC, rd); chk("R3 full mask", rd, 8'h5A);
        apb_rd(12'h03C, rd); chk("R3 low mask", rd, 8'h0A);
        apb_rd(12'h000, rd); chk("R3 empty mask", rd, 8'h00);
        apb_rd(12'h048, rd); chk("R6 synced bits", rd, 8'h12);

        // R5 hardware mode
        @(negedge pclk); hw_out = 8'h33; hw_oe = 8'hC3;
        apb_wr(12'h420, 8'h0F); m_mode = 8'h0F;
        apb_rd(12'h420, rd); chk("R5 mode readback", rd, 8'h0F);
        chk("R5 out", gpio_out, 8'hA3);
        chk("R5 oe", gpio_oe, 8'hF3);

        // R7 pending bits and falling edges
        apb_rd(12'h414, rd); chk("R7 rise latched", rd, 8'h5A);
        set_pins(8'h00);
        apb_rd(12'h414, rd); chk("R7 fall ignored", rd, 8'h5A);

        // R9 enable and combined interrupt
        chk("R9 irq masked", irq, 1'b0);
        apb_wr(12'h410, 8'h02); m_ie = 8'h02;
        apb_rd(12'h418, rd); chk("R9 masked status", rd, 8'h02);
        chk("R9 irq on", irq, 1'b1);

        // R8 clear
        apb_wr(12'h41C, 8'h00); apb_rd(12'h414, rd); chk("R8 zero clear", rd, 8'h5A);
        apb_wr(12'h41C, 8'h02); m_raw = 8'h58;
        apb_rd(12'h414, rd); chk("R8 cleared", rd, 8'h58);
        chk("R8 irq off", irq, 1'b0);

        // R10 unmapped and read-only
        apb_rd(12'h404, rd); chk("R10 404", rd, 8'h00);
        apb_rd(12'h408, rd); chk("R10 408", rd, 8'h00);
        apb_rd(12'h40C, rd); chk("R10 40C", rd, 8'h00);
        apb_rd(12'h800, rd); chk("R10 800", rd, 8'h00);
        apb_rd(12'h401, rd); chk("R10 unaligned", rd, 8'h00);
        apb_wr(12'h414, 8'hFF); apb_wr(12'h418, 8'hFF); apb_wr(12'h404, 8'hFF);
        apb_wr(12'h402, 8'h00); apb_wr(12'h3FD, 8'h00);
        apb_rd(12'h414, rd); chk("R10 raw kept", rd, 8'h58);
        apb_rd(12'h400, rd); chk("R10 dir kept", rd, 8'hFF);
        apb_rd(12'h410, rd); chk("R10 ie kept", rd, 8'h02);
        apb_rd(12'h420, rd); chk("R10 mode kept", rd, 8'h0F);
        chk_pins("R10 pins kept");

        // R11 bare enable cycle ignored
        @(negedge pclk); psel = 1; penable = 1; pwrite = 1; paddr = 12'h400; pwdata = 8'h00;
        @(negedge pclk); psel = 0; penable = 0; pwrite = 0;
        apb_rd(12'h400, rd); chk("R11 bare enable", rd, 8'hFF);

        // Random mix
        for (int it = 0; it < 400; it++) begin
            int op;
            op = $urandom % 7;
            case (op)
                0: begin
                    msk = 8'($urandom);
                    rd = 8'($urandom);
                    apb_wr({2'b00, msk, 2'b00}, rd);
                    m_data = (m_data & ~msk) | (rd & msk);
                    chk_pins("R2 random write");
                end
                1: begin
                    set_pins(8'($urandom));
                    chk_pins("R7 random pins");
                end
                2: begin
                    msk = 8'($urandom);
                    apb_rd({2'b00, msk, 2'b00}, rd);
                    chk("R3 random read", rd, m_pin & msk);
                end
                3: begin
                    rd = 8'($urandom);
                    apb_wr(12'h41C, rd); m_raw = m_raw & ~rd;
                    apb_rd(12'h414, rd); chk("R8 random clear", rd, m_raw);
                end
                4: begin
                    rd = 8'($urandom);
                    case ($urandom % 3)
                        0: begin apb_wr(12'h400, rd); m_dir = rd; end
                        1: begin apb_wr(12'h410, rd); m_ie = rd; end
                        default: begin apb_wr(12'h420, rd); m_mode = rd; end
                    endcase
                    chk_pins("R5 random control");
                end
                5: begin
                    @(negedge pclk); hw_out = 8'($urandom); hw_oe = 8'($urandom);
                    #1 chk_pins("R5 random hw");
                end
                default: begin
                    apb_rd(12'h418, rd); chk("R9 random masked", rd, m_raw & m_ie);
                end
            endcase
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule